// File: doc/BRIEF.md
# Bus Activity Monitor with Watermarks

The block watches one source of bus traffic. Every cycle in which the event input pulses, a programmable weight is added to an accumulator. A millisecond tick input paces a programmable sampling period. When a period ends, the accumulated count becomes that period's sample and the accumulator restarts from zero. The sample feeds an exponential moving average whose window is a power of two, set by a small constant K. The block also checks the sample against an upper and a lower watermark.

A breach of either raw-count watermark only raises an interrupt once it has happened in a programmed number of back-to-back periods. The new average is checked against its own pair of watermarks. Interrupt causes are held in a sticky status register until software clears them. The interrupt output is the OR of those status bits, each gated by its enable. Software controls everything through a plain register port: writes take effect on the clock edge, and reads are combinational from the address. The event input accepts one pulse per cycle and has no back-pressure. The tick, the interrupt and the register port are plain level or pulse signals.

Top module: `act_mon_top`

## Requirements
- R1: After reset, every register reads zero and the interrupt output is low.
- R2: The period register (offset 0x1C) keeps the low 8 bits of a write and holds the period length P minus one, in ticks, so the longest period is 256 ms. A period ends on the tick that completes P ticks. Ticks are counted only while the master enable (control bit 31) and the periodic enable (control bit 18) are both set.
- R3: Each cycle with the event input high adds the count weight (offset 0x18) to the accumulator, which saturates at all ones. The accumulator returns to zero at each period end, and it is held at zero while the master enable is clear.
- R4: At a period end, with K in control bits 12:10, the average becomes avg - (avg >> (K+1)) + (sample >> (K+1)).
- R5: A write to offset 0xC loads the average directly. Offset 0x20 reads the average, and writes to 0x20 change nothing.
- R6: When a sample is strictly above the upper watermark (0x4) for N periods in a row, status bit 31 is set. N-1 is held in control bits 28:26, and the enable is control bit 30. The run restarts at zero after a sample that is not above the watermark, and after firing.
- R7: When a sample is strictly below the lower watermark (0x8) for N periods in a row, status bit 30 is set. N-1 is held in control bits 25:23, and the enable is control bit 29. The run restarts in the same way as in R6.
- R8: Clearing a consecutive enable bit discards the partial run of breaches it guards.
- R9: At a period end, a new average strictly above offset 0x10 sets status bit 29 when control bit 21 is set. A new average strictly below offset 0x14 sets status bit 28 when control bit 20 is set.
- R10: Status bits (offset 0x24) stay set until written with a one, so writing all ones clears them all. A cause arriving in the same cycle as a clear wins.
- R11: The interrupt output is high when any status bit is set together with its enable: bit 31 with control 30, bit 30 with control 29, bit 29 with control 21, and bit 28 with control 20.
- R12: Writing zero to control stops the monitor: no period ends, the average is frozen and the interrupt output is low.
- R13: Control and the watermark, weight and period registers read back what was written. Unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_pulse | input | 1 | One bus event per high cycle |
| ms_tick | input | 1 | One-cycle millisecond tick |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and an 8-bit period field. It programs periods of two or three ticks, so that dozens of complete sampling periods fit in a short run. Small weights and watermarks let hand-chosen event counts land just above, at, or below each threshold. This puts the exact breach-run lengths, the resets of the runs, and the one-tick-early boundary of the period within reach. A weight near all ones with the widest K setting drives the accumulator into saturation and exercises the largest shift.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;
  localparam int unsigned KW = 3;
  localparam int unsigned CW = 3;

  localparam logic [AW-1:0] OFF_CTRL = 6'h00;
  localparam logic [AW-1:0] OFF_UP   = 6'h04;
  localparam logic [AW-1:0] OFF_LO   = 6'h08;
  localparam logic [AW-1:0] OFF_SEED = 6'h0C;
  localparam logic [AW-1:0] OFF_AUP  = 6'h10;
  localparam logic [AW-1:0] OFF_ALO  = 6'h14;
  localparam logic [AW-1:0] OFF_WGT  = 6'h18;
  localparam logic [AW-1:0] OFF_PER  = 6'h1C;
  localparam logic [AW-1:0] OFF_AVG  = 6'h20;
  localparam logic [AW-1:0] OFF_STAT = 6'h24;

  // status bit 31..28 map onto stat vector index 3..0
  localparam int unsigned NSTAT   = 4;
  localparam int unsigned STAT_LSB = 28;

  typedef struct packed {
    logic          master;
    logic          run;
    logic [KW-1:0] k;
    logic [CW-1:0] up_lim;
    logic [CW-1:0] lo_lim;
    logic          up_en;
    logic          lo_en;
    logic          aup_en;
    logic          alo_en;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [DW-1:0] w);
    ctrl_t c;
    c.master = w[31];
    c.run    = w[31] & w[18];
    c.k      = w[12:10];
    c.up_lim = w[28:26];
    c.lo_lim = w[25:23];
    c.up_en  = w[30];
    c.lo_en  = w[29];
    c.aup_en = w[21];
    c.alo_en = w[20];
    return c;
  endfunction
endpackage

// File: rtl/act_mon_timer.sv
module act_mon_timer #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          period_end
);
  logic [PW-1:0] tcnt;

  assign period_end = run && tick && (tcnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tcnt <= '0;
    else if (!run)       tcnt <= '0;
    else if (period_end) tcnt <= '0;
    else if (tick)       tcnt <= tcnt + 1'b1;
  end

  // R2: a new period always starts counting from zero
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (tcnt == '0));
endmodule

// File: rtl/act_mon_accum.sv
module act_mon_accum import act_mon_pkg::*; #(
  parameter int unsigned W = DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          evt,
  input  logic [W-1:0]  weight,
  input  logic          period_end,
  input  logic [KW-1:0] k,
  input  logic          seed_we,
  input  logic [W-1:0]  seed_val,
  output logic [W-1:0]  sample,
  output logic [W-1:0]  avg,
  output logic [W-1:0]  avg_upd
);
  localparam int unsigned SW = KW + 1;

  logic [W-1:0] acc;
  logic [W:0]   sum;
  logic [SW-1:0] shift;

  assign sum    = {1'b0, acc} + {1'b0, weight};
  assign sample = !evt ? acc : (sum[W] ? '1 : sum[W-1:0]);
  assign shift  = SW'(k) + 1'b1;
  assign avg_upd = avg - (avg >> shift) + (sample >> shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      acc <= '0;
    else if (!enable || period_end) acc <= '0;
    else                            acc <= sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          avg <= '0;
    else if (seed_we)    avg <= seed_val;
    else if (period_end) avg <= avg_upd;
  end

  // R3: accumulator idles at zero while the monitor is off
  a_r3_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (acc == '0));
  // R4: the average moves only at a period end or a seed write
  a_r4_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !seed_we) |=> $stable(avg));
endmodule

// File: rtl/act_mon_streak.sv
module act_mon_streak #(
  parameter int unsigned CNTW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            strobe,
  input  logic            hit,
  input  logic [CNTW-1:0] lim,
  output logic            fire
);
  logic [CNTW-1:0] cnt;

  assign fire = en && strobe && hit && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (strobe) begin
      if (!hit || fire) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  // R6: a run grows by at most one per period, otherwise it restarts
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == '0) || (cnt == $past(cnt) + 1'b1)));
  // R8: a cleared enable leaves no partial run behind
  a_r8_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/act_mon_regs.sv
module act_mon_regs import act_mon_pkg::*; #(
  parameter int unsigned PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [DW-1:0]    avg_in,
  input  logic [NSTAT-1:0] stat_set,
  output logic [DW-1:0]    ctrl,
  output logic [DW-1:0]    up_wm,
  output logic [DW-1:0]    lo_wm,
  output logic [DW-1:0]    aup_wm,
  output logic [DW-1:0]    alo_wm,
  output logic [DW-1:0]    weight,
  output logic [PW-1:0]    period,
  output logic             seed_we,
  output logic [DW-1:0]    seed_val,
  output logic [NSTAT-1:0] status
);
  logic stat_wr;

  assign seed_we  = we && (addr == OFF_SEED);
  assign seed_val = wdata;
  assign stat_wr  = we && (addr == OFF_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      up_wm  <= '0;
      lo_wm  <= '0;
      aup_wm <= '0;
      alo_wm <= '0;
      weight <= '0;
      period <= '0;
    end else if (we) begin
      case (addr)
        OFF_CTRL: ctrl   <= wdata;
        OFF_UP:   up_wm  <= wdata;
        OFF_LO:   lo_wm  <= wdata;
        OFF_AUP:  aup_wm <= wdata;
        OFF_ALO:  alo_wm <= wdata;
        OFF_WGT:  weight <= wdata;
        OFF_PER:  period <= wdata[PW-1:0];
        default:  ;
      endcase
    end
  end

  for (genvar i = 0; i < NSTAT; i++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= stat_set[i] |
                               (status[i] & ~(stat_wr & wdata[STAT_LSB+i]));
    end

    // R10: a status bit stays set until a one is written to it
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(stat_wr && wdata[STAT_LSB+i])) |=> status[i]);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CTRL: rdata = ctrl;
      OFF_UP:   rdata = up_wm;
      OFF_LO:   rdata = lo_wm;
      OFF_AUP:  rdata = aup_wm;
      OFF_ALO:  rdata = alo_wm;
      OFF_WGT:  rdata = weight;
      OFF_PER:  rdata = DW'(period);
      OFF_AVG:  rdata = avg_in;
      OFF_STAT: rdata = {status, {STAT_LSB{1'b0}}};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/act_mon_top.sv
module act_mon_top import act_mon_pkg::*; #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          evt_pulse,
  input  logic          ms_tick,
  output logic          irq
);
  localparam int unsigned NSTREAK = 2;

  logic [DW-1:0]    ctrl_w, up_wm, lo_wm, aup_wm, alo_wm, weight, seed_val;
  logic [DW-1:0]    sample, avg, avg_upd;
  logic [PW-1:0]    period;
  logic             seed_we, period_end;
  logic [NSTAT-1:0] status, stat_set, stat_en;
  ctrl_t            c;

  logic [NSTREAK-1:0]   s_en, s_hit, s_fire;
  logic [CW-1:0]        s_lim [NSTREAK];

  assign c = decode_ctrl(ctrl_w);

  act_mon_regs #(.PW(PW)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .avg_in(avg),
    .stat_set(stat_set), .ctrl(ctrl_w), .up_wm(up_wm), .lo_wm(lo_wm),
    .aup_wm(aup_wm), .alo_wm(alo_wm), .weight(weight), .period(period),
    .seed_we(seed_we), .seed_val(seed_val), .status(status)
  );

  act_mon_timer #(.PW(PW)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(c.run), .tick(ms_tick),
    .period(period), .period_end(period_end)
  );

  act_mon_accum #(.W(DW)) accum_i (
    .clk(clk), .rst_n(rst_n), .enable(c.master), .evt(evt_pulse),
    .weight(weight), .period_end(period_end), .k(c.k),
    .seed_we(seed_we), .seed_val(seed_val), .sample(sample),
    .avg(avg), .avg_upd(avg_upd)
  );

  // index 0: above the upper watermark, index 1: below the lower one
  assign s_en[0]  = c.master & c.up_en;
  assign s_hit[0] = sample > up_wm;
  assign s_lim[0] = c.up_lim;
  assign s_en[1]  = c.master & c.lo_en;
  assign s_hit[1] = sample < lo_wm;
  assign s_lim[1] = c.lo_lim;

  for (genvar g = 0; g < NSTREAK; g++) begin : g_streak
    act_mon_streak #(.CNTW(CW)) streak_i (
      .clk(clk), .rst_n(rst_n), .en(s_en[g]), .strobe(period_end),
      .hit(s_hit[g]), .lim(s_lim[g]), .fire(s_fire[g])
    );
  end

  assign stat_set[3] = s_fire[0];
  assign stat_set[2] = s_fire[1];
  assign stat_set[1] = period_end && c.aup_en && (avg_upd > aup_wm);
  assign stat_set[0] = period_end && c.alo_en && (avg_upd < alo_wm);

  assign stat_en = {c.up_en, c.lo_en, c.aup_en, c.alo_en};
  assign irq     = |(status & stat_en);

  // R12: a stopped monitor never closes a period
  a_r12_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w == '0) |-> !period_end);
  // R7: a below-run cause reaches the status register on the next edge
  a_r7_below_lands: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire[1] |=> status[2]);
endmodule

// File: tb/act_mon_tb_top.sv
module act_mon_tb_top;
  import act_mon_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          evt_pulse = 1'b0;
  logic          ms_tick = 1'b0;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_q [$];
  logic [31:0] m_avg = '0, m_wgt = '0;
  int          m_k = 0, m_per = 0;

  localparam logic [31:0] BASE = 32'h8000_0000 | 32'h0004_0000 | 32'h4000_0000 |
                                 32'h2000_0000 | (32'd1 << 26) | (32'd2 << 23);

  always #4 clk = ~clk;

  act_mon_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .ms_tick(ms_tick), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic events(input int n);
    for (int e = 0; e < n; e++) begin
      @(negedge clk); evt_pulse = 1'b1;
    end
    @(negedge clk); evt_pulse = 1'b0;
  endtask

  // driver: runs one full period and pushes the expected average
  task automatic run_period(input int n);
    logic [63:0] smp, a;
    int s;
    events(n);
    ticks(m_per + 1);
    smp = 64'(n) * 64'(m_wgt);
    if (smp > 64'hFFFF_FFFF) smp = 64'hFFFF_FFFF;
    s = m_k + 1;
    a = 64'(m_avg);
    a = a - (a >> s) + (smp >> s);
    m_avg = a[31:0];
    exp_q.push_back(m_avg);
  endtask

  // monitor: pops the expected average and compares with the design
  task automatic mon_avg(input string tag);
    logic [31:0] d, e;
    e = exp_q.pop_front();
    rd(OFF_AVG, d);
    chk(tag, d, e);
  endtask

  task automatic chk_stat(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(OFF_STAT, d);
    chk(tag, d, exp);
  endtask

  task automatic seed(input logic [31:0] v);
    wr(OFF_SEED, v);
    m_avg = v;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(OFF_CTRL, d); chk("R1 ctrl", d, 0);
    rd(OFF_AVG, d);  chk("R1 avg", d, 0);
    chk_stat("R1 status", 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // configuration and R13 readback
    wr(OFF_WGT, 32'd4);    m_wgt = 4;
    wr(OFF_PER, 32'h1FF);
    rd(OFF_PER, d); chk("R2 period truncated", d, 32'hFF);
    wr(OFF_PER, 32'd1);    m_per = 1;
    wr(OFF_UP, 32'd40);
    wr(OFF_LO, 32'd8);
    wr(OFF_AUP, 32'hFFFF_FFFF);
    wr(OFF_ALO, 32'd0);
    rd(OFF_UP, d);  chk("R13 upper readback", d, 40);
    rd(OFF_WGT, d); chk("R13 weight readback", d, 4);
    rd(6'h2C, d);   chk("R13 unused offset", d, 0);
    seed(32'd1000);
    rd(OFF_AVG, d); chk("R5 seed", d, 1000);
    wr(OFF_CTRL, BASE); m_k = 0;
    rd(OFF_CTRL, d); chk("R13 ctrl readback", d, BASE);

    // R6 above-run of two, R3/R4 averages
    run_period(5);  mon_avg("R4 avg p1");
    run_period(12); mon_avg("R3 avg p2");
    chk_stat("R6 one breach only", 0);
    run_period(5);  mon_avg("R4 avg p3");
    run_period(11); mon_avg("R4 avg p4");
    chk_stat("R6 run broken", 0);
    run_period(15); mon_avg("R4 avg p5");
    chk_stat("R6 fired", 32'h8000_0000);
    chk("R11 irq above", {31'b0, irq}, 1);

    // R10 clear
    wr(OFF_STAT, 32'hFFFF_FFFF);
    chk_stat("R10 cleared", 0);
    chk("R10 irq low", {31'b0, irq}, 0);

    // R7 below-run of three
    run_period(1); mon_avg("R4 avg b1");
    run_period(1); mon_avg("R4 avg b2");
    chk_stat("R7 two below", 0);
    run_period(1); mon_avg("R4 avg b3");
    chk_stat("R7 fired", 32'h4000_0000);
    chk("R11 irq below", {31'b0, irq}, 1);
    wr(OFF_STAT, 32'hFFFF_FFFF);

    // R8 enable clear drops partial run
    run_period(11); mon_avg("R4 avg e1");
    wr(OFF_CTRL, BASE & ~32'h4000_0000);
    wr(OFF_CTRL, BASE);
    run_period(11); mon_avg("R4 avg e2");
    chk_stat("R8 run discarded", 0);
    run_period(11); mon_avg("R4 avg e3");
    chk_stat("R8 new run fires", 32'h8000_0000);

    // R10 sticky and R11 gating
    run_period(5); mon_avg("R4 avg s1");
    chk_stat("R10 sticky", 32'h8000_0000);
    wr(OFF_CTRL, BASE & ~32'h4000_0000);
    chk("R11 gated irq", {31'b0, irq}, 0);
    chk_stat("R11 status kept", 32'h8000_0000);
    wr(OFF_CTRL, BASE);
    chk("R11 irq back", {31'b0, irq}, 1);
    wr(OFF_STAT, 32'hFFFF_FFFF);

    // R5 write to average offset ignored
    rd(OFF_AVG, keep);
    wr(OFF_AVG, 32'h1234);
    rd(OFF_AVG, d); chk("R5 avg write ignored", d, keep);

    // R9 average watermarks
    wr(OFF_AUP, 32'd0);
    wr(OFF_CTRL, BASE | 32'h0020_0000);
    run_period(5); mon_avg("R4 avg w1");
    chk_stat("R9 avg above", 32'h2000_0000);
    chk("R11 irq avg above", {31'b0, irq}, 1);
    wr(OFF_STAT, 32'hFFFF_FFFF);
    wr(OFF_AUP, 32'hFFFF_FFFF);
    wr(OFF_ALO, 32'hFFFF_FFFF);
    wr(OFF_CTRL, BASE | 32'h0010_0000);
    run_period(5); mon_avg("R4 avg w2");
    chk_stat("R9 avg below", 32'h1000_0000);
    wr(OFF_CTRL, BASE);
    wr(OFF_STAT, 32'hFFFF_FFFF);
    wr(OFF_ALO, 32'd0);

    // R4 with K=2
    wr(OFF_CTRL, BASE | (32'd2 << 10)); m_k = 2;
    run_period(8); mon_avg("R4 K2 a");
    run_period(3); mon_avg("R4 K2 b");

    // R2 period of three ticks
    wr(OFF_CTRL, BASE); m_k = 0;
    wr(OFF_PER, 32'd2); m_per = 2;
    seed(32'd100);
    events(10);
    ticks(2);
    rd(OFF_AVG, d); chk("R2 not yet ended", d, 100);
    ticks(1);
    rd(OFF_AVG, d); chk("R2 ended on third tick", d, 70);
    m_avg = 70;

    // R3 saturation with the widest shift
    wr(OFF_WGT, 32'hFFFF_FFF0); m_wgt = 32'hFFFF_FFF0;
    wr(OFF_CTRL, 32'h8004_0000 | (32'd7 << 10)); m_k = 7;
    seed(32'd0);
    run_period(2); mon_avg("R3 saturated sample");
    chk("R3 saturated value", m_avg, 32'h00FF_FFFF);

    // R12 stop
    wr(OFF_STAT, 32'hFFFF_FFFF);
    wr(OFF_CTRL, 32'd0);
    rd(OFF_AVG, keep);
    events(3);
    ticks(4);
    rd(OFF_AVG, d); chk("R12 avg frozen", d, keep);
    chk("R12 irq low", {31'b0, irq}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule